// File: doc/BRIEF.md
# Word-Based Receive Frame Parser

This block examines an incoming Ethernet frame, delivered as a stream of 32-bit words, against a programmable rule table. Each rule points at one word of the frame. It holds a 32-bit reference value and a 32-bit compare-enable mask, and it carries an action that either lets the frame through or drops it. Rules are tried from the lowest index upward. The first rule that matches fully decides the frame. The top entry of the table is a built-in fallback that lets every frame through.

A field that starts at byte offset B lives in word B/4. When B is not a multiple of four, the field straddles two words. Software then programs a linked pair of rules. The head rule has its link flag set and compares the upper part of word N. The following entry acts as its fragment and compares the lower part of word N+1. The pair counts as a match only when both halves agree, and the action always comes from the head. Only the first MAX_BYTE_OFF/4 + 1 words of a frame are inspected. The verdict comes out as soon as the last inspected word or the frame's final word has been seen, whichever comes first.

Rules are loaded through a single-cycle write strobe that writes every field of one entry at a time. Rules should be written only between frames.

Top module: `fwp_parser`

## Requirements
- R1: After reset, no verdict is pending, and every programmable entry is empty, with neither the pass flag nor the drop flag set, so the first frame is decided by the fallback entry.
- R2: A verdict pulse (v_valid high for one cycle) is presented in the cycle after the word that ends inspection is accepted, together with v_accept and v_index.
- R3: A rule compares word `cfg_word_off` of the frame (word 0 is the first word). Bit k takes part only when mask bit k is 1 and then must equal value bit k. A mask bit of 0 makes bit k a don't-care.
- R4: Among all rules that match, the one with the lowest index decides the verdict.
- R5: A matching rule with its drop flag set gives v_accept = 0, and the drop flag wins when both flags are set. A rule with its pass flag set and its drop flag clear gives v_accept = 1. A rule with neither flag set never decides.
- R6: When entry i has its link flag set, entry i+1 is its fragment. Entry i decides only if both entry i and entry i+1 match, and the action comes from entry i. A fragment never decides on its own. For byte offset B with r = B mod 4 not zero, the head compares bits 31..8r of word B/4 and the fragment compares bits 8r-1..0 of word B/4+1. A link flag written to entry DEPTH-2 is discarded.
- R7: When no rule decides, the verdict is pass with v_index = DEPTH-1. Writes to entry DEPTH-1 are ignored.
- R8: A rule whose word offset lies at or beyond the frame's word count does not match.
- R9: Inspection stops after word MAX_BYTE_OFF/4. If the frame is longer, the verdict follows that word, the remaining words up to s_last produce nothing, and a rule with a larger offset never matches. The word after s_last starts a new frame.
- R10: Each frame produces exactly one verdict, and match state never carries over from one frame to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one rule entry |
| cfg_idx | input | $clog2(DEPTH) | Entry index to write |
| cfg_word_off | input | $clog2(MAX_BYTE_OFF/4+1) | Frame word the rule compares |
| cfg_value | input | 32 | Reference value |
| cfg_mask | input | 32 | Compare-enable mask |
| cfg_pass | input | 1 | Pass action flag |
| cfg_drop | input | 1 | Drop action flag |
| cfg_link | input | 1 | Next entry is this rule's fragment |
| s_valid | input | 1 | Frame word present |
| s_data | input | 32 | Frame word |
| s_last | input | 1 | Final word of the frame |
| v_valid | output | 1 | Verdict pulse |
| v_accept | output | 1 | 1 = pass, 0 = drop |
| v_index | output | $clog2(DEPTH) | Entry that decided |

## Verification
Match flags that are stale or set at the wrong time show up in the very next verdict. They produce a wrong index or a wrong action, often the fallback index appearing where a programmed rule should have won, or a programmed rule winning where the fallback should have. A word counter that is off by one moves the verdict pulse by one cycle, and that shows on the same frame. A counter that fails to stop at the inspection limit shows as an extra or missing pulse during the tail of a long frame. A fault in the link logic appears only on frames where exactly one half of a straddling pair agrees, so those mixed cases are driven on purpose.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

  typedef struct packed {
    logic [31:0] value;
    logic [31:0] mask;
    logic        pass;
    logic        drop;
    logic        link;
  } rule_t;

  // bits enabled by the mask must agree; the rest are ignored
  function automatic logic masked_equal(input logic [31:0] data,
                                        input logic [31:0] value,
                                        input logic [31:0] mask);
    return ((data ^ value) & mask) == 32'd0;
  endfunction

  // a rule can decide only if it carries an action
  function automatic logic has_action(input rule_t r);
    return r.pass | r.drop;
  endfunction

  // drop wins over pass
  function automatic logic verdict_of(input rule_t r);
    return r.pass & ~r.drop;
  endfunction

endpackage

// File: rtl/fwp_rule_table.sv
module fwp_rule_table
  import fwp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OFFW  = 5,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [OFFW-1:0] word_off,
  input  logic [31:0]     value,
  input  logic [31:0]     mask,
  input  logic            pass,
  input  logic            drop,
  input  logic            link,
  output logic [OFFW-1:0] ent_off  [DEPTH],
  output rule_t           ent_rule [DEPTH],
  output logic [DEPTH-1:0] ent_frag
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == DEPTH - 1) begin : g_fallback
      // fixed pass-all rule: offset 0, empty mask, pass action
      assign ent_off[i]  = '0;
      assign ent_rule[i] = '{value: 32'd0, mask: 32'd0, pass: 1'b1, drop: 1'b0, link: 1'b0};
    end else begin : g_prog
      logic [OFFW-1:0] off_q;
      rule_t           rule_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          off_q  <= '0;
          rule_q <= '0;
        end else if (we && idx == IDXW'(i)) begin
          off_q        <= word_off;
          rule_q.value <= value;
          rule_q.mask  <= mask;
          rule_q.pass  <= pass;
          rule_q.drop  <= drop;
          // the fallback entry may never become a fragment
          rule_q.link  <= (i == DEPTH - 2) ? 1'b0 : link;
        end
      end
      assign ent_off[i]  = off_q;
      assign ent_rule[i] = rule_q;
    end

    if (i == 0) begin : g_nofrag
      assign ent_frag[i] = 1'b0;
    end else begin : g_frag
      assign ent_frag[i] = ent_rule[i-1].link;
    end
  end

endmodule

// File: rtl/fwp_match_lanes.sv
module fwp_match_lanes
  import fwp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OFFW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_fire,
  input  logic             frame_clear,
  input  logic [OFFW-1:0]  word_cnt,
  input  logic [31:0]      data,
  input  logic [OFFW-1:0]  ent_off  [DEPTH],
  input  rule_t            ent_rule [DEPTH],
  output logic [DEPTH-1:0] seen
);

  logic [DEPTH-1:0] hit_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_lane
    logic cur_hit;
    logic hit_q;
    assign cur_hit = word_fire && (word_cnt == ent_off[i]) &&
                     masked_equal(data, ent_rule[i].value, ent_rule[i].mask);
    always_ff @(posedge clk) begin
      if (!rst_n)           hit_q <= 1'b0;
      else if (frame_clear) hit_q <= 1'b0;
      else if (cur_hit)     hit_q <= 1'b1;
    end
    assign hit_vec[i] = hit_q;
    // the word being accepted counts in the same cycle
    assign seen[i]    = hit_q | cur_hit;
  end

  // R10
  hits_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clear |=> (hit_vec == '0));

endmodule

// File: rtl/fwp_verdict_select.sv
module fwp_verdict_select
  import fwp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] seen,
  input  rule_t            ent_rule [DEPTH],
  input  logic [DEPTH-1:0] ent_frag,
  output logic [IDXW-1:0]  sel_idx,
  output logic             sel_pass
);

  logic [DEPTH-1:0] win;

  always_comb begin
    for (int i = 0; i < DEPTH - 1; i++) begin
      win[i] = !ent_frag[i] && has_action(ent_rule[i]) && seen[i] &&
               (!ent_rule[i].link || seen[i+1]);
    end
    win[DEPTH-1] = 1'b1;
  end

  // lowest winning index takes precedence
  always_comb begin
    sel_idx = IDXW'(DEPTH - 1);
    for (int i = DEPTH - 2; i >= 0; i--) begin
      if (win[i]) sel_idx = IDXW'(i);
    end
    sel_pass = verdict_of(ent_rule[sel_idx]);
  end

endmodule

// File: rtl/fwp_parser.sv
module fwp_parser
  import fwp_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int MAX_BYTE_OFF = 64,
  localparam int IDXW     = $clog2(DEPTH),
  localparam int MAX_WORD = MAX_BYTE_OFF / 4,
  localparam int OFFW     = $clog2(MAX_WORD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [OFFW-1:0] cfg_word_off,
  input  logic [31:0]     cfg_value,
  input  logic [31:0]     cfg_mask,
  input  logic            cfg_pass,
  input  logic            cfg_drop,
  input  logic            cfg_link,
  input  logic            s_valid,
  input  logic [31:0]     s_data,
  input  logic            s_last,
  output logic            v_valid,
  output logic            v_accept,
  output logic [IDXW-1:0] v_index
);

  logic [OFFW-1:0]  ent_off  [DEPTH];
  rule_t            ent_rule [DEPTH];
  logic [DEPTH-1:0] ent_frag;
  logic [DEPTH-1:0] seen;
  logic [IDXW-1:0]  sel_idx;
  logic             sel_pass;

  logic [OFFW-1:0]  word_cnt;
  logic             frame_done;
  logic             word_fire;
  logic             decide;
  logic             at_limit;

  assign word_fire = s_valid && !frame_done;
  assign at_limit  = (word_cnt == OFFW'(MAX_WORD));
  assign decide    = word_fire && (s_last || at_limit);

  fwp_rule_table #(.DEPTH(DEPTH), .OFFW(OFFW)) u_table (
    .clk, .rst_n,
    .we(cfg_we), .idx(cfg_idx), .word_off(cfg_word_off),
    .value(cfg_value), .mask(cfg_mask),
    .pass(cfg_pass), .drop(cfg_drop), .link(cfg_link),
    .ent_off, .ent_rule, .ent_frag
  );

  fwp_match_lanes #(.DEPTH(DEPTH), .OFFW(OFFW)) u_lanes (
    .clk, .rst_n,
    .word_fire, .frame_clear(decide), .word_cnt, .data(s_data),
    .ent_off, .ent_rule, .seen
  );

  fwp_verdict_select #(.DEPTH(DEPTH)) u_select (
    .seen, .ent_rule, .ent_frag, .sel_idx, .sel_pass
  );

  // word position within the current frame
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_cnt   <= '0;
      frame_done <= 1'b0;
    end else if (s_valid && s_last) begin
      word_cnt   <= '0;
      frame_done <= 1'b0;
    end else if (word_fire) begin
      if (at_limit) frame_done <= 1'b1;
      else          word_cnt   <= word_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_valid  <= 1'b0;
      v_accept <= 1'b0;
      v_index  <= '0;
    end else begin
      v_valid <= decide;
      if (decide) begin
        v_accept <= sel_pass;
        v_index  <= sel_idx;
      end
    end
  end

  // R2
  verdict_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_valid |-> $past(s_valid));

  // R9
  tail_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && frame_done) |=> !v_valid);

  // R7
  fallback_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_valid && v_index == IDXW'(DEPTH - 1)) |-> v_accept);

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= OFFW'(MAX_WORD));

endmodule

// File: tb/fwp_parser_test.sv
module fwp_parser_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int MAXB       = 64;
  localparam int MAXW       = MAXB / 4;
  localparam int LAST       = DEPTH - 1;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [5:0]  cfg_idx = 0;
  logic [4:0]  cfg_word_off = 0;
  logic [31:0] cfg_value = 0, cfg_mask = 0;
  logic        cfg_pass = 0, cfg_drop = 0, cfg_link = 0;
  logic        s_valid = 0, s_last = 0;
  logic [31:0] s_data = 0;
  logic        v_valid, v_accept;
  logic [5:0]  v_index;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model of the rule table
  int          m_off  [DEPTH];
  logic [31:0] m_val  [DEPTH];
  logic [31:0] m_mask [DEPTH];
  bit          m_pass [DEPTH], m_drop [DEPTH], m_link [DEPTH];
  logic [31:0] m_words [$];
  bit          m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwp_parser #(.DEPTH(DEPTH), .MAX_BYTE_OFF(MAXB)) uut (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_word_off, .cfg_value, .cfg_mask,
    .cfg_pass, .cfg_drop, .cfg_link, .s_valid, .s_data, .s_last,
    .v_valid, .v_accept, .v_index
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit word_ok(int j);
    if (m_off[j] >= m_words.size()) return 0;
    return ((m_words[m_off[j]] ^ m_val[j]) & m_mask[j]) == 0;
  endfunction

  // returns {pass, index}
  function automatic int model_verdict();
    for (int i = 0; i < LAST; i++) begin
      if (i > 0 && m_link[i-1]) continue;
      if (!(m_pass[i] || m_drop[i])) continue;
      if (word_ok(i) && (!m_link[i] || word_ok(i+1)))
        return ((m_pass[i] && !m_drop[i]) ? 256 : 0) + i;
    end
    return 256 + LAST;
  endfunction

  task automatic write_rule(input int idx, input int off, input logic [31:0] val,
                            input logic [31:0] msk, input bit p, input bit d, input bit l);
    cfg_we = 1; cfg_idx = 6'(idx); cfg_word_off = 5'(off);
    cfg_value = val; cfg_mask = msk; cfg_pass = p; cfg_drop = d; cfg_link = l;
    @(posedge clk); #1;
    cfg_we = 0;
    if (idx != LAST) begin
      m_off[idx] = off; m_val[idx] = val; m_mask[idx] = msk;
      m_pass[idx] = p; m_drop[idx] = d; m_link[idx] = (idx == LAST-1) ? 0 : l;
    end
  endtask

  task automatic clear_table();
    for (int i = 0; i < LAST; i++) write_rule(i, 0, 0, 0, 0, 0, 0);
  endtask

  // drive one word, then compare the outputs after the edge
  task automatic send_word(input logic [31:0] d, input bit last, input string tag);
    bit decide;
    int v;
    s_valid = 1; s_data = d; s_last = last;
    decide = 0;
    if (!m_done) begin
      m_words.push_back(d);
      decide = last || (m_words.size() - 1 == MAXW);
    end
    @(posedge clk); #1;
    s_valid = 0; s_last = 0;
    chk(v_valid == decide, tag, "v_valid", int'(v_valid), int'(decide));
    if (decide) begin
      v = model_verdict();
      chk(v_accept == v[8], tag, "v_accept", int'(v_accept), v[8]);
      chk(int'(v_index) == v % 256, tag, "v_index", int'(v_index), v % 256);
    end
    if (last) begin
      m_words.delete(); m_done = 0;
    end else if (decide) begin
      m_done = 1;
    end
  endtask

  task automatic send_frame(input logic [31:0] fr[$], input string tag);
    foreach (fr[k]) send_word(fr[k], k == fr.size() - 1, tag);
  endtask

  // expect a specific verdict for the frame just sent
  task automatic expect_last(input bit p, input int idx, input string tag);
    chk(v_accept == p && int'(v_index) == idx, tag, "directed verdict",
        int'(v_index) + (v_accept ? 256 : 0), idx + (p ? 256 : 0));
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      chk(v_valid == 0, tag, "idle v_valid", int'(v_valid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] fr[$];
    for (int i = 0; i < DEPTH; i++) begin
      m_off[i] = 0; m_val[i] = 0; m_mask[i] = 0;
      m_pass[i] = 0; m_drop[i] = 0; m_link[i] = 0;
    end
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    // R1: quiet after reset, empty table defers to fallback
    idle(2, "R1");
    fr = '{32'hDEAD_BEEF, 32'h0};
    send_frame(fr, "R1"); expect_last(1, LAST, "R1");

    // R2 R3: exact match at word 1
    write_rule(3, 1, 32'h1234_5678, 32'hFFFF_FFFF, 1, 0, 0);
    fr = '{32'h0, 32'h1234_5678, 32'h5};
    send_frame(fr, "R2"); expect_last(1, 3, "R2");
    fr = '{32'h0, 32'h1234_5679, 32'h5};
    send_frame(fr, "R3"); expect_last(1, LAST, "R3");
    // R3: masked-out bits are don't-care
    write_rule(3, 1, 32'h1234_0000, 32'hFFFF_0000, 1, 0, 0);
    fr = '{32'h0, 32'h1234_ABCD};
    send_frame(fr, "R3"); expect_last(1, 3, "R3");
    fr = '{32'h0, 32'h1235_ABCD};
    send_frame(fr, "R3"); expect_last(1, LAST, "R3");
    clear_table();

    // R4 R5: lower index wins, drop action
    write_rule(10, 0, 0, 0, 1, 0, 0);
    write_rule(5, 0, 0, 0, 0, 1, 0);
    fr = '{32'h77};
    send_frame(fr, "R4"); expect_last(0, 5, "R4");
    write_rule(2, 0, 0, 0, 0, 0, 0);
    send_frame(fr, "R5"); expect_last(0, 5, "R5");
    write_rule(1, 0, 0, 0, 1, 1, 0);
    send_frame(fr, "R5"); expect_last(0, 1, "R5");
    clear_table();

    // R6: byte offset 6, key AABBCCDD split at r=2
    write_rule(7, 1, 32'hCCDD_0000, 32'hFFFF_0000, 0, 1, 1);
    write_rule(8, 2, 32'h0000_AABB, 32'h0000_FFFF, 1, 0, 0);
    fr = '{32'h0, 32'hCCDD_1111, 32'h2222_AABB};
    send_frame(fr, "R6"); expect_last(0, 7, "R6");
    fr = '{32'h0, 32'hCCDD_1111, 32'h2222_AABC};
    send_frame(fr, "R6"); expect_last(1, LAST, "R6");
    fr = '{32'h0, 32'hCCDE_1111, 32'h2222_AABB};
    send_frame(fr, "R6"); expect_last(1, LAST, "R6");
    // R6: link on entry DEPTH-2 is discarded
    write_rule(LAST-1, 0, 0, 0, 0, 1, 1);
    fr = '{32'h9};
    send_frame(fr, "R6"); expect_last(0, LAST-1, "R6");
    clear_table();

    // R8: offset past end of frame
    write_rule(4, 5, 0, 0, 1, 0, 0);
    fr = '{32'h1, 32'h2, 32'h3};
    send_frame(fr, "R8"); expect_last(1, LAST, "R8");
    write_rule(0, 0, 0, 0, 0, 1, 0);
    write_rule(0, 0, 32'h1, 32'hFFFF_FFFF, 0, 1, 0);
    fr = '{32'h5, 32'h2, 32'h3, 32'h4, 32'h5, 32'h6};
    send_frame(fr, "R8"); expect_last(1, 4, "R8");
    clear_table();

    // R9: early verdict at the inspection limit, tail ignored
    write_rule(0, MAXW, 32'hCAFE_F00D, 32'hFFFF_FFFF, 0, 1, 0);
    write_rule(1, MAXW + 1, 0, 0, 1, 0, 0);
    fr = {};
    for (int k = 0; k < 20; k++) fr.push_back(k == MAXW ? 32'hCAFE_F00D : 32'(k));
    send_frame(fr, "R9");
    fr = '{32'hAB};
    send_frame(fr, "R9"); expect_last(1, LAST, "R9");
    fr = {};
    for (int k = 0; k < 20; k++) fr.push_back(32'(k));
    send_frame(fr, "R9");
    clear_table();

    // R7: writes to the fallback entry are ignored
    write_rule(LAST, 0, 0, 0, 0, 1, 0);
    fr = '{32'h3, 32'h4};
    send_frame(fr, "R7"); expect_last(1, LAST, "R7");

    // R10: back-to-back single-word frames, no carry-over
    write_rule(6, 0, 32'h55, 32'hFF, 1, 0, 0);
    fr = '{32'h55}; send_frame(fr, "R10"); expect_last(1, 6, "R10");
    fr = '{32'h56}; send_frame(fr, "R10"); expect_last(1, LAST, "R10");
    fr = '{32'h155}; send_frame(fr, "R10"); expect_last(1, 6, "R10");
    idle(3, "R10");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule